// File: doc/BRIEF.md
# UART Modem Status Register

This block watches four active-low handshake lines coming from a modem (clear to send, data set ready, ring indicator, carrier detect). It shows them to the CPU as one 8-bit status byte. The upper nibble gives the present asserted level of each line. The lower nibble holds sticky change flags. The CPU clears these flags by reading the byte. Whenever any flag is set, a modem-status interrupt request is raised.

For self-test, a loop control from the modem control register disconnects the external lines. In their place, the block observes the four modem control outputs (RTS, DTR, OUT1, OUT2). Both the level bits and the change flags then follow those outputs.

External lines pass through a two-flop synchronizer before any edge logic. The CPU port is a single-cycle read strobe with a register-select address. The byte returned is the value held before the read clears it.

Top module: `uart_modem_status`

## Requirements
- R1: Bit 0 becomes 1 after the clear-to-send line (`modem_in_n[0]`) changes level in either direction, and it stays 1 until a register read.
- R2: Bit 1 becomes 1 after the data-set-ready line (`modem_in_n[1]`) changes level in either direction, and it stays 1 until a read.
- R3: Bit 2 becomes 1 only when the ring line (`modem_in_n[2]`) goes from low to high. A high-to-low change leaves it 0.
- R4: Bit 3 becomes 1 after the carrier-detect line (`modem_in_n[3]`) changes level in either direction, and it stays 1 until a read.
- R5: A read is `rd_stb`=1 with `rd_addr` equal to `STATUS_ADDR` (default 6). It returns the current byte, and bits 0 to 3 are 0 from the next cycle on. A strobe with any other address returns 0x00 and clears nothing.
- R6: `irq` is 1 exactly while any of bits 0 to 3 is 1.
- R7: With `loop_en`=0, bits 4, 5, 6 and 7 are the inverted levels of `modem_in_n[0]`, `[1]`, `[2]` and `[3]`.
- R8: With `loop_en`=1, bits 4 to 7 equal `ctl_out[0]` (RTS), `[1]` (DTR), `[2]` (OUT1) and `[3]` (OUT2). The external lines have no effect.
- R9: With `loop_en`=1, change detection runs on `ctl_out`. A toggle of RTS, DTR or OUT2 sets the matching flag, and a 1-to-0 change of OUT1 sets bit 2.
- R10: When a change event and a read fall in the same cycle, the flag for that event is 1 after the read.
- R11: An external line change shows in bits 4 to 7 two clock edges after it is applied, and in its change flag and `irq` three edges after it is applied.
- R12: After reset, with all lines inactive (high) and `ctl_out`=0, the byte reads 0x00 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| modem_in_n | input | 4 | Active-low modem lines: [0] clear to send, [1] data set ready, [2] ring, [3] carrier detect |
| loop_en | input | 1 | Loop bit from the modem control register |
| ctl_out | input | 4 | Modem control outputs: [0] RTS, [1] DTR, [2] OUT1, [3] OUT2 |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_addr | input | 3 | Register select |
| rd_data | output | 8 | Status byte during a selected read, else 0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench applies an external line change just after a falling edge. It checks that `irq` is still low after the first and second rising edges and high after the third. Level bits are read back only once the two synchronizer edges have passed. Loopback stimulus reaches the level bits within the same cycle and the flags at the next edge, so loopback reads come one cycle after a change. Read data is sampled combinationally within the strobe cycle. Clearing is judged by a second read or by `irq` one cycle later, and the same-cycle race drives the event and the strobe together before that edge.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned LINES = 4;

  typedef enum logic [1:0] {
    LN_CTS = 2'd0,
    LN_DSR = 2'd1,
    LN_RI  = 2'd2,
    LN_DCD = 2'd3
  } line_idx_e;

  typedef enum logic {
    EDGE_BOTH = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  typedef logic [LINES-1:0] line_vec_t;

  // ring reports only the end of a ring: asserted level falling
  function automatic edge_kind_e edge_kind_of(input int unsigned idx);
    if (idx == int'(LN_RI)) return EDGE_FALL;
    return EDGE_BOTH;
  endfunction
endpackage

// File: rtl/msr_rst_sync.sv
module msr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH    = 4,
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = din;
    end else begin : g_rest
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= {WIDTH{IDLE_VAL}};
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/msr_change_det.sv
module msr_change_det
  import msr_pkg::*;
#(
  parameter int unsigned WIDTH = LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev,
  output logic [WIDTH-1:0] evt
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb prev_d = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    if (edge_kind_of(i) == EDGE_FALL) begin : g_fall
      always_comb evt[i] = prev_q[i] & ~cur[i];
    end else begin : g_both
      always_comb evt[i] = prev_q[i] ^ cur[i];
    end
  end

  assign prev = prev_q;
endmodule

// File: rtl/msr_event_latch.sv
module msr_event_latch #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_evt,
  input  logic             clr,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;
  logic             flag_en;

  always_comb begin
    flag_en = clr | (|set_evt);
    flag_d  = (clr ? '0 : flag_q) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flags = flag_q;
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import msr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned STATUS_ADDR = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  modem_in_n,
  input  logic              loop_en,
  input  logic [LINES-1:0]  ctl_out,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [2*LINES-1:0] rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(STATUS_ADDR);

  logic      rst_sync_n;
  line_vec_t ext_sync_n;
  line_vec_t cur_vec;
  line_vec_t prev_vec;
  line_vec_t evt_vec;
  line_vec_t delta_vec;
  logic      rd_hit;

  msr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (modem_in_n),
    .dout  (ext_sync_n)
  );

  // asserted-level view: external lines inverted, or control outputs when looped
  always_comb begin
    if (loop_en) cur_vec = ctl_out;
    else         cur_vec = ~ext_sync_n;
  end

  msr_change_det #(.WIDTH(LINES)) u_det (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cur   (cur_vec),
    .prev  (prev_vec),
    .evt   (evt_vec)
  );

  always_comb rd_hit = rd_stb & (rd_addr == SEL);

  msr_event_latch #(.WIDTH(LINES)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_evt (evt_vec),
    .clr     (rd_hit),
    .flags   (delta_vec)
  );

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = {cur_vec, delta_vec};
  end

  assign irq = |delta_vec;
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
  parameter int unsigned W = 4
) (
  input logic           clk,
  input logic           rst_ni,
  input logic           rd_hit,
  input logic           loop_en,
  input logic [W-1:0]   ctl_out,
  input logic [2*W-1:0] rd_data,
  input logic           irq,
  input logic [W-1:0]   cur_vec,
  input logic [W-1:0]   prev_vec,
  input logic [W-1:0]   evt_vec,
  input logic [W-1:0]   delta_vec
);
  a_r1_cts_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (delta_vec[0] && !rd_hit) |=> delta_vec[0]);

  a_r3_ring_trailing_only: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(delta_vec[2]) |-> $past(prev_vec[2] && !cur_vec[2]));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_hit && evt_vec == '0) |=> (delta_vec == '0));

  a_r6_irq_after_event: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_vec != '0) |=> irq);

  a_r6_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> $past(evt_vec != '0));

  a_r8_loop_levels: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_hit && loop_en) |-> (rd_data[2*W-1:W] == ctl_out));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_hit && evt_vec != '0) |=> ((delta_vec & $past(evt_vec)) == $past(evt_vec)));
endmodule

bind uart_modem_status msr_checker #(.W(msr_pkg::LINES)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .rd_hit    (rd_hit),
  .loop_en   (loop_en),
  .ctl_out   (ctl_out),
  .rd_data   (rd_data),
  .irq       (irq),
  .cur_vec   (cur_vec),
  .prev_vec  (prev_vec),
  .evt_vec   (evt_vec),
  .delta_vec (delta_vec)
);

// File: tb/uart_modem_status_test.sv
module uart_modem_status_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] modem_in_n;
  logic       loop_en;
  logic [3:0] ctl_out;
  logic       rd_stb;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  uart_modem_status uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .modem_in_n (modem_in_n),
    .loop_en    (loop_en),
    .ctl_out    (ctl_out),
    .rd_stb     (rd_stb),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // selected read: strobe for one cycle, sample within it
  task automatic do_read(output logic [7:0] v);
    rd_stb  = 1'b1;
    rd_addr = 3'd6;
    #1 v = rd_data;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [7:0] exp);
    logic [7:0] v;
    do_read(v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R12 irq", {7'd0, irq}, 8'h00);
    read_expect("R12 byte", 8'h00);
  endtask

  task automatic t_latency;
    modem_in_n[0] = 1'b0;
    step(1); chk("R11 irq after 1 edge", {7'd0, irq}, 8'h00);
    step(1); chk("R11 irq after 2 edges", {7'd0, irq}, 8'h00);
    step(1); chk("R11 irq after 3 edges", {7'd0, irq}, 8'h01);
    read_expect("R1 R7 cts asserted", 8'h11);
    read_expect("R5 cleared", 8'h10);
    chk("R6 irq low after read", {7'd0, irq}, 8'h00);
    modem_in_n[0] = 1'b1;
    step(3);
    read_expect("R1 cts released", 8'h01);
    read_expect("R5 cleared again", 8'h00);
  endtask

  task automatic t_dsr_dcd;
    modem_in_n[1] = 1'b0; step(3);
    read_expect("R2 dsr asserted", 8'h22);
    modem_in_n[1] = 1'b1; step(3);
    read_expect("R2 dsr released", 8'h02);
    modem_in_n[3] = 1'b0; step(3);
    read_expect("R4 dcd asserted", 8'h88);
    modem_in_n[3] = 1'b1; step(3);
    read_expect("R4 dcd released", 8'h08);
    read_expect("R5 after dcd", 8'h00);
  endtask

  task automatic t_ring;
    modem_in_n[2] = 1'b0; step(3);
    chk("R3 no irq on ring start", {7'd0, irq}, 8'h00);
    read_expect("R3 ring start level only", 8'h40);
    modem_in_n[2] = 1'b1; step(3);
    chk("R6 irq on ring end", {7'd0, irq}, 8'h01);
    read_expect("R3 ring end", 8'h04);
    read_expect("R5 after ring", 8'h00);
  endtask

  task automatic t_all_lines;
    modem_in_n = 4'h0; step(3);
    read_expect("R7 all asserted", 8'hFB);
    modem_in_n = 4'hF; step(3);
    read_expect("R7 all released", 8'h0F);
    read_expect("R5 after all", 8'h00);
  endtask

  task automatic t_other_addr;
    modem_in_n[0] = 1'b0; step(3);
    rd_stb = 1'b1; rd_addr = 3'd3;
    #1 chk("R5 other address data", rd_data, 8'h00);
    @(negedge clk); rd_stb = 1'b0;
    chk("R5 other address keeps irq", {7'd0, irq}, 8'h01);
    read_expect("R5 flag kept", 8'h11);
    modem_in_n[0] = 1'b1; step(3);
    read_expect("R5 restore", 8'h01);
  endtask

  task automatic t_loop;
    loop_en = 1'b1; ctl_out = 4'h0; step(1);
    ctl_out = 4'b0101; step(1);
    read_expect("R9 rts toggles, out1 rise ignored", 8'h51);
    ctl_out = 4'b0000; step(1);
    read_expect("R9 rts and out1 fall", 8'h05);
    ctl_out = 4'b1000; step(1);
    read_expect("R8 R9 out2", 8'h88);
    ctl_out = 4'b0000; step(1);
    read_expect("R9 out2 fall", 8'h08);
    modem_in_n[0] = 1'b0; step(3);
    chk("R8 external ignored irq", {7'd0, irq}, 8'h00);
    read_expect("R8 external ignored", 8'h00);
    modem_in_n[0] = 1'b1; step(3);
    read_expect("R8 external ignored again", 8'h00);
  endtask

  task automatic t_event_wins;
    logic [7:0] v;
    ctl_out = 4'b0010;
    rd_stb = 1'b1; rd_addr = 3'd6;
    #1 v = rd_data;
    chk("R10 data during race", v, 8'h20);
    @(negedge clk); rd_stb = 1'b0;
    chk("R10 irq kept", {7'd0, irq}, 8'h01);
    read_expect("R10 flag kept", 8'h22);
    ctl_out = 4'b0000; step(1);
    read_expect("R9 dtr fall", 8'h02);
    loop_en = 1'b0; step(3);
    read_expect("R7 back to external", 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; modem_in_n = 4'hF; loop_en = 1'b0;
    ctl_out = 4'h0; rd_stb = 1'b0; rd_addr = 3'd0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_latency();
    t_dsr_dcd();
    t_ring();
    t_all_lines();
    t_other_addr();
    t_loop();
    t_event_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0x00 expected=0x01");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule